// File: doc/BRIEF.md
# Tick-Sequenced Frame-Sync Pulse Generator

This block drives a frame-sync square wave from a free-running timestamp tick enable. It holds a small bank of programmable edge entries. Each entry carries a duration counted in timestamp ticks, a flag that says whether the output flips when that duration ends, and a flag that returns the sequence to the first entry. Once enabled, the block counts ticks against the current entry. When the count reaches the entry's duration, it applies the entry's flags and moves on to the next entry.

Entries are normally used in pairs: one entry sets the first phase of a period and the next sets the second phase. A program that spans several pairs, with the second phase of some periods one tick longer than the others, gives a repeating run of uneven period lengths. This spreads a fractional tick remainder over several periods, so the mean frequency matches the target exactly and does not drift against the timestamp base. Software writes the entries through a plain write port while the block is stopped, then raises the enable.

Top module: `edge_seq_pulse_gen`

## Requirements
- R1: While reset is held, and while the enable is low, `pulse_out` is 0.
- R2: `wr_en` writes `wr_data` into the entry selected by `wr_addr` (0..7). Bits [OFS_W-1:0] hold the duration in ticks, bit OFS_W is the flip flag and bit OFS_W+1 is the loop flag. Entries are used in order 0,1,2,... and each one ends after its duration in ticks.
- R3: The tick count of an entry advances only in cycles where `tick_en` is 1. With no tick, the output holds its level.
- R4: When an entry with the loop flag ends, the next entry is entry 0.
- R5: When entry 7 ends without a loop flag, the sequence wraps to entry 0.
- R6: A duration of 0 behaves as a duration of 1 tick.
- R7: An entry whose flip flag is 0 leaves the output unchanged when it ends, so its duration adds to the current level.
- R8: Clearing the enable forces `pulse_out` to 0 at the next clock edge, and the output stays at 0 while the enable stays low.
- R9: The clock edge that first sees the enable high starts the sequence at entry 0 with a cleared tick count and the output at 0. With a tick in every cycle, an entry of duration K that flips ends K edges after that starting edge.
- R10: A program of several pairs, where only the last entry has the loop flag, repeats its full run of uneven phase lengths without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the sequence while high; output low when low |
| tick_en | input | 1 | One-cycle timestamp tick |
| wr_en | input | 1 | Entry write strobe |
| wr_addr | input | 3 | Entry index to write |
| wr_data | input | OFS_W+2 | {loop flag, flip flag, duration} |
| pulse_out | output | 1 | Generated frame-sync wave |

## Verification
The hardest case to reach from the ports is the wrap from the last entry back to entry 0 when no entry has the loop flag. In normal use a loop flag always ends the program early. The bench fills all eight entries with distinct durations and flip flags set but no loop flag, then measures each phase length through the wrap. Tick gating is checked with a tick only in every third cycle, comparing steady-state phase lengths against three times the programmed durations. A stop in the middle of a phase is followed by a restart, and the first phase length shows that the count and the entry index were cleared.

// File: rtl/esg_pkg.sv
// Package: shared entry flag type and field positions for the edge-sequenced
// pulse generator. Assumes the write word is {flags, offset}.
package esg_pkg;
    localparam int FLAG_W = 2;

    // Control flags stored with every edge entry.
    typedef struct packed {
        logic loop_back;
        logic flip;
    } esg_flags_t;
endpackage

// File: rtl/esg_entry_bank.sv
// Entry bank: stores NUM_ENTRIES edge entries (offset + flags) written via a
// single write port, and reads the entry selected by rd_idx combinationally.
// Assumes wr_addr is in range; all entries clear to zero on reset.
module esg_entry_bank
    import esg_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int OFS_W       = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [OFS_W+FLAG_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [OFS_W-1:0]   rd_ofs,
    output esg_flags_t         rd_flags
);
    logic [OFS_W-1:0] ofs_q   [NUM_ENTRIES];
    esg_flags_t       flags_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        // Capture one entry when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q[g]   <= '0;
                flags_q[g] <= '0;
            end else if (wr_en && (wr_addr == IDX_W'(g))) begin
                ofs_q[g]   <= wr_data[OFS_W-1:0];
                flags_q[g] <= esg_flags_t'(wr_data[OFS_W+FLAG_W-1:OFS_W]);
            end
        end
    end

    // Present the currently selected entry.
    always_comb begin
        rd_ofs   = ofs_q[rd_idx];
        rd_flags = flags_q[rd_idx];
    end
endmodule

// File: rtl/esg_tick_counter.sv
// Tick counter: counts tick pulses for the current entry and flags the tick
// that completes it. A zero limit counts as one tick. Assumes clear is held
// while the sequence is not running.
module esg_tick_counter #(
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [OFS_W-1:0] limit,
    output logic             done,
    output logic [OFS_W-1:0] count
);
    logic [OFS_W-1:0] eff_limit;
    logic [OFS_W:0]   count_inc;

    // Derive the effective limit and the completing tick.
    always_comb begin
        eff_limit = (limit == '0) ? OFS_W'(1) : limit;
        count_inc = {1'b0, count} + 1'b1;
        done      = !clear && tick && (count_inc >= {1'b0, eff_limit});
    end

    // Advance on ticks, restart on completion or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || done) begin
            count <= '0;
        end else if (tick) begin
            count <= count_inc[OFS_W-1:0];
        end
    end
endmodule

// File: rtl/esg_sequencer.sv
// Sequencer: tracks run state, the current entry index and the output level.
// Applies the flip and loop flags when an entry completes; wraps after the
// last entry. Assumes step_done is only raised while running.
module esg_sequencer
    import esg_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             step_done,
    input  esg_flags_t       flags,
    output logic             running,
    output logic [IDX_W-1:0] idx,
    output logic             level
);
    logic last_entry;

    // Decide whether the next entry is entry 0.
    always_comb begin
        last_entry = flags.loop_back || (idx == IDX_W'(NUM_ENTRIES - 1));
    end

    // Start, stop and step through the entries.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running <= 1'b0;
            idx     <= '0;
            level   <= 1'b0;
        end else if (!running) begin
            running <= 1'b1;
            idx     <= '0;
            level   <= 1'b0;
        end else if (step_done) begin
            level <= level ^ flags.flip;
            idx   <= last_entry ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/edge_seq_pulse_gen.sv
// Top: edge-sequenced frame-sync pulse generator. Entries are written while
// stopped; raising enable starts at entry 0 with the output low and counts
// tick_en pulses against each entry's offset.
module edge_seq_pulse_gen
    import esg_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int OFS_W       = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    tick_en,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic [OFS_W+FLAG_W-1:0] wr_data,
    output logic                    pulse_out
);
    logic             run_q;
    logic [IDX_W-1:0] cur_idx;
    logic [OFS_W-1:0] cur_ofs;
    esg_flags_t       cur_flags;
    logic             cur_loop;
    logic             step_done;
    logic [OFS_W-1:0] cnt_q;
    logic             cnt_clear;
    logic             cnt_tick;

    // Gate counting to the running state.
    always_comb begin
        cnt_clear = !enable || !run_q;
        cnt_tick  = tick_en && run_q && enable;
        cur_loop  = cur_flags.loop_back;
    end

    esg_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES), .OFS_W(OFS_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_idx   (cur_idx),
        .rd_ofs   (cur_ofs),
        .rd_flags (cur_flags)
    );

    esg_tick_counter #(.OFS_W(OFS_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .tick  (cnt_tick),
        .limit (cur_ofs),
        .done  (step_done),
        .count (cnt_q)
    );

    esg_sequencer #(.NUM_ENTRIES(NUM_ENTRIES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .step_done (step_done),
        .flags     (cur_flags),
        .running   (run_q),
        .idx       (cur_idx),
        .level     (pulse_out)
    );
endmodule

// File: rtl/esg_checker.sv
// Checker: temporal properties of the pulse generator, bound to the top.
// Assumes entries are not rewritten while the sequence runs.
module esg_checker #(
    parameter int NUM_ENTRIES = 8,
    parameter int OFS_W       = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             tick_en,
    input logic             pulse_out,
    input logic             run,
    input logic [IDX_W-1:0] idx,
    input logic [OFS_W-1:0] cnt,
    input logic [OFS_W-1:0] cur_ofs,
    input logic             cur_loop,
    input logic             step_done
);
    assert_low_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pulse_out);

    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick_en) |=> $stable(pulse_out));

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && enable) |-> ({1'b0, cnt} < ((cur_ofs == '0) ? {{OFS_W{1'b0}}, 1'b1} : {1'b0, cur_ofs})));

    assert_loop_to_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && cur_loop && enable) |=> (idx == '0));

    assert_zero_offset_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && enable && tick_en && cur_ofs == '0 && !cur_loop &&
         idx != IDX_W'(NUM_ENTRIES - 1)) |=> (idx == $past(idx) + 1'b1));
endmodule

bind edge_seq_pulse_gen esg_checker #(.NUM_ENTRIES(NUM_ENTRIES), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick_en   (tick_en),
    .pulse_out (pulse_out),
    .run       (run_q),
    .idx       (cur_idx),
    .cnt       (cnt_q),
    .cur_ofs   (cur_ofs),
    .cur_loop  (cur_loop),
    .step_done (step_done)
);

// File: tb/edge_seq_pulse_gen_tb.sv
module edge_seq_pulse_gen_tb;
    localparam int N  = 8;
    localparam int OW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic tick_en = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [OW+1:0] wr_data = '0;
    logic pulse_out;

    int checks = 0;
    int errors = 0;
    logic prev_out = 1'b0;
    logic tick_div = 1'b0;
    int div_cnt = 0;

    always #2 clk = ~clk;

    edge_seq_pulse_gen #(.NUM_ENTRIES(N), .OFS_W(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pulse_out(pulse_out)
    );

    // Tick pattern: every cycle, or every third cycle when tick_div is set.
    always @(negedge clk) begin
        div_cnt = (div_cnt + 1) % 3;
        tick_en = tick_div ? (div_cnt == 0) : 1'b1;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int ofs, input bit flip, input bit lp);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 3'(idx);
        wr_data = {lp, flip, OW'(ofs)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_and_clear();
        @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < N; i++) wr(i, 0, 1'b0, 1'b0);
    endtask

    task automatic start();
        @(negedge clk);
        enable = 1'b1;
        prev_out = 1'b0;
    endtask

    // Negedges until pulse_out changes (first phase reads K+1 after start).
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pulse_out == prev_out && n < 5000);
        prev_out = pulse_out;
    endtask

    task automatic expect_seq(input string req, input int exp[]);
        int n;
        foreach (exp[i]) begin
            measure(n);
            chk(req, n, exp[i]);
        end
    endtask

    task automatic test_reset();
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset low", int'(pulse_out), 0);
        enable = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 disabled low", int'(pulse_out), 0);
    endtask

    task automatic test_basic_pair();
        stop_and_clear();
        wr(0, 5, 1, 0);
        wr(1, 7, 1, 1);
        start();
        expect_seq("R2 R4 R9 pair", '{6, 7, 5, 7, 5});
    endtask

    task automatic test_multi_period();
        stop_and_clear();
        wr(0, 4, 1, 0); wr(1, 6, 1, 0);
        wr(2, 4, 1, 0); wr(3, 6, 1, 0);
        wr(4, 4, 1, 0); wr(5, 5, 1, 1);
        start();
        expect_seq("R10 uneven loop", '{5, 6, 4, 6, 4, 5, 4, 6, 4, 6, 4, 5});
    endtask

    task automatic test_wrap();
        stop_and_clear();
        for (int i = 0; i < N; i++) wr(i, i + 2, 1, 0);
        start();
        expect_seq("R5 wrap", '{3, 3, 4, 5, 6, 7, 8, 9, 2, 3});
    endtask

    task automatic test_no_flip();
        stop_and_clear();
        wr(0, 3, 1, 0);
        wr(1, 2, 0, 0);
        wr(2, 4, 1, 1);
        start();
        expect_seq("R7 no flip", '{4, 6, 3, 6});
    endtask

    task automatic test_zero();
        stop_and_clear();
        wr(0, 0, 1, 0);
        wr(1, 3, 1, 1);
        start();
        expect_seq("R6 zero offset", '{2, 3, 1, 3, 1});
    endtask

    task automatic test_tick_gate();
        int n;
        stop_and_clear();
        wr(0, 2, 1, 0);
        wr(1, 3, 1, 1);
        tick_div = 1'b1;
        start();
        measure(n);
        expect_seq("R3 tick gating", '{9, 6, 9});
        tick_div = 1'b0;
    endtask

    task automatic test_stop_restart();
        int toggles = 0;
        stop_and_clear();
        wr(0, 5, 1, 0);
        wr(1, 7, 1, 1);
        start();
        expect_seq("R9 start", '{6});
        repeat (3) @(negedge clk);
        chk("R8 high before stop", int'(pulse_out), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R8 low after stop", int'(pulse_out), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pulse_out) toggles++;
        end
        chk("R8 stays low", toggles, 0);
        start();
        expect_seq("R9 restart from entry 0", '{6, 7});
    endtask

    initial begin
        test_reset();
        test_basic_pair();
        test_multi_period();
        test_wrap();
        test_no_flip();
        test_zero();
        test_tick_gate();
        test_stop_restart();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule